// File: doc/BRIEF.md
# Dual-Channel Window Filter Bank

This block checks the latest 10-bit readings of two analog channels against a bank of eight window filters. Each filter is a pair of windows, one per channel. Each window has a lower bound, an upper bound, a sense bit and an enable bit. The sense bit picks whether a reading must fall inside the window or outside it. A pair reports a hit only when every enabled window in it matches.

The sampling sequencer pulses an evaluate strobe once both channel readings are present. One cycle later the block presents an 8-bit hit vector and a one-cycle valid pulse, which a downstream debounce stage can consume. Windows are programmed one at a time through a parallel write port that carries a pair index and a channel select.

Top module: `win_filter_bank`

## Requirements
- R1: After reset, `hit_o` is 0, `hit_vld_o` is 0 and every window is disabled.
- R2: When `cfg_we_i` is high at a clock edge, the window for channel `cfg_chan_i` (0 or 1) of pair `cfg_idx_i` takes `cfg_lo_i`, `cfg_hi_i`, `cfg_out_i` and `cfg_en_i`. Evaluations at later edges use these values.
- R3: When `cfg_out_i` = 0 (inside sense), a window matches a reading v when lo <= v <= hi, with both bounds inclusive.
- R4: When `cfg_out_i` = 1 (outside sense), a window matches when v < lo or v > hi. This is the exact inverse of inside sense.
- R5: A pair hits when at least one of its windows is enabled and every enabled window in it matches. A disabled window inside an enabled pair does not block the hit.
- R6: A pair whose two windows are both disabled never hits.
- R7: Bit i of `hit_o` belongs to pair i. On a clock edge where `eval_i` is high, `hit_o` is loaded from the readings present at that edge and `hit_vld_o` goes high for exactly the following cycle.
- R8: Between evaluations, `hit_o` holds its value and `hit_vld_o` stays low, even when the readings change.
- R9: With bounds 0 and 1023, an inside window matches every reading and an outside window matches none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Window write strobe |
| cfg_idx_i | input | 3 | Pair index of the write |
| cfg_chan_i | input | 1 | Channel of the write |
| cfg_lo_i | input | 10 | Lower bound |
| cfg_hi_i | input | 10 | Upper bound |
| cfg_out_i | input | 1 | Sense: 0 inside, 1 outside |
| cfg_en_i | input | 1 | Window enable |
| smp0_i | input | 10 | Latest reading, channel 0 |
| smp1_i | input | 10 | Latest reading, channel 1 |
| eval_i | input | 1 | Evaluate strobe |
| hit_o | output | 8 | Registered pair hit vector |
| hit_vld_o | output | 1 | One-cycle pulse marking a fresh `hit_o` |

## Verification
A window write is usable by an evaluate strobe issued on any later edge. The result of an evaluation appears on `hit_o` and `hit_vld_o` one register after the edge that samples `eval_i`. The bench drives every input on the falling edge and reads the outputs on the next falling edge, so each result is sampled in the cycle it is due. After each evaluation, the bench changes the readings without a strobe and waits one more cycle. It then checks that the vector held its value and that the valid pulse did not repeat.

// File: rtl/win_filter_bank.sv
module win_filter_bank #(
  parameter int NPAIR = 8,
  parameter int VW    = 10,
  localparam int IW   = $clog2(NPAIR),
  localparam int NCH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IW-1:0]    cfg_idx_i,
  input  logic             cfg_chan_i,
  input  logic [VW-1:0]    cfg_lo_i,
  input  logic [VW-1:0]    cfg_hi_i,
  input  logic             cfg_out_i,
  input  logic             cfg_en_i,
  input  logic [VW-1:0]    smp0_i,
  input  logic [VW-1:0]    smp1_i,
  input  logic             eval_i,
  output logic [NPAIR-1:0] hit_o,
  output logic             hit_vld_o
);

  logic [VW-1:0]    smp [NCH];
  logic [NPAIR-1:0] pair_en;
  logic [NPAIR-1:0] pair_hit;

  assign smp[0] = smp0_i;
  assign smp[1] = smp1_i;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic [NCH-1:0] en_q, out_q, pass;
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      logic [VW-1:0] lo_q, hi_q;
      logic          inwin;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lo_q     <= '0;
          hi_q     <= '0;
          out_q[c] <= 1'b0;
          en_q[c]  <= 1'b0;
        end else if (cfg_we_i && cfg_idx_i == IW'(p) && cfg_chan_i == 1'(c)) begin
          lo_q     <= cfg_lo_i;
          hi_q     <= cfg_hi_i;
          out_q[c] <= cfg_out_i;
          en_q[c]  <= cfg_en_i;
        end
      end
      assign inwin   = (smp[c] >= lo_q) && (smp[c] <= hi_q);
      assign pass[c] = !en_q[c] || (inwin ^ out_q[c]);
    end
    assign pair_en[p]  = |en_q;
    assign pair_hit[p] = pair_en[p] && (&pass);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o     <= '0;
      hit_vld_o <= 1'b0;
    end else begin
      hit_vld_o <= eval_i;
      if (eval_i) hit_o <= pair_hit;
    end
  end

  p_vld_after_eval_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |=> hit_vld_o);
  p_no_vld_without_eval_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> !hit_vld_o);
  p_hit_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> $stable(hit_o));
  p_disabled_pair_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |=> (hit_o & ~$past(pair_en)) == '0);

endmodule

// File: tb/test_win_filter_bank.sv
module test_win_filter_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] idx = '0;
  logic       chan = 1'b0;
  logic [9:0] lo = '0, hi = '0;
  logic       outs = 1'b0, en = 1'b0;
  logic [9:0] s0 = '0, s1 = '0;
  logic       ev = 1'b0;
  logic [7:0] hit;
  logic       vld;

  int total = 0, bad = 0;
  logic [9:0] m_lo [2][8];
  logic [9:0] m_hi [2][8];
  logic       m_out [2][8];
  logic       m_en [2][8];

  always #5 clk = ~clk;

  win_filter_bank i_win_filter_bank (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_idx_i(idx), .cfg_chan_i(chan),
    .cfg_lo_i(lo), .cfg_hi_i(hi), .cfg_out_i(outs), .cfg_en_i(en),
    .smp0_i(s0), .smp1_i(s1), .eval_i(ev), .hit_o(hit), .hit_vld_o(vld));

  function automatic logic [7:0] model(input logic [9:0] a, input logic [9:0] b);
    logic [7:0] r;
    for (int p = 0; p < 8; p++) begin
      logic ok;
      ok = m_en[0][p] || m_en[1][p];
      for (int c = 0; c < 2; c++) begin
        logic [9:0] v;
        logic m;
        v = (c == 0) ? a : b;
        if (m_out[c][p]) m = (v < m_lo[c][p]) || (v > m_hi[c][p]);
        else             m = (v >= m_lo[c][p]) && (v <= m_hi[c][p]);
        if (m_en[c][p] && !m) ok = 1'b0;
      end
      r[p] = ok;
    end
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int p, input int c, input int l, input int h,
                    input logic o, input logic e);
    @(negedge clk);
    we = 1'b1; idx = 3'(p); chan = 1'(c); lo = 10'(l); hi = 10'(h); outs = o; en = e;
    m_lo[c][p] = 10'(l); m_hi[c][p] = 10'(h); m_out[c][p] = o; m_en[c][p] = e;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic evaluate(input int a, input int b, input string req);
    logic [7:0] exp;
    @(negedge clk);
    s0 = 10'(a); s1 = 10'(b); ev = 1'b1;
    exp = model(10'(a), 10'(b));
    @(negedge clk);
    ev = 1'b0;
    check(req, hit, exp);
    check("R7 valid pulse", vld, 1);
    s0 = 10'($urandom); s1 = 10'($urandom);
    @(negedge clk);
    check("R8 hold", hit, exp);
    check("R8 no valid", vld, 0);
  endtask

  task automatic clear_all();
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 2; c++) wr(p, c, 0, 0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 2; c++) begin
        m_lo[c][p] = '0; m_hi[c][p] = '0; m_out[c][p] = 1'b0; m_en[c][p] = 1'b0;
      end
    repeat (3) @(negedge clk);
    check("R1 hit reset", hit, 0);
    check("R1 vld reset", vld, 0);
    rst_n = 1'b1;
    evaluate(0, 0, "R1 nothing enabled");

    // R3 inclusive bounds, R5 other channel disabled
    wr(0, 0, 7, 23, 1'b0, 1'b1);
    evaluate(7, 500, "R3 at lo");
    evaluate(23, 500, "R3 at hi");
    evaluate(6, 500, "R3 below lo");
    evaluate(24, 500, "R3 above hi");
    // R4 outside sense
    wr(1, 1, 7, 23, 1'b1, 1'b1);
    evaluate(0, 6, "R4 below lo");
    evaluate(0, 7, "R4 at lo");
    evaluate(0, 24, "R4 above hi");
    // R5 AND of both channels
    wr(2, 0, 100, 200, 1'b0, 1'b1);
    wr(2, 1, 300, 400, 1'b0, 1'b1);
    evaluate(150, 350, "R5 both match");
    evaluate(150, 450, "R5 ch1 misses");
    evaluate(50, 350, "R5 ch0 misses");
    // R9 degenerate bounds
    wr(3, 0, 0, 1023, 1'b0, 1'b1);
    wr(4, 1, 0, 1023, 1'b1, 1'b1);
    evaluate(0, 0, "R9 zero");
    evaluate(1023, 1023, "R9 full scale");
    // R6 disabling a pair, R2 rewrite takes effect
    wr(3, 0, 0, 1023, 1'b0, 1'b0);
    evaluate(512, 512, "R6 pair disabled");
    wr(3, 1, 500, 520, 1'b0, 1'b1);
    evaluate(512, 512, "R2 rewrite used");

    // random configurations and readings
    for (int round = 0; round < 20; round++) begin
      clear_all();
      for (int p = 0; p < 8; p++)
        for (int c = 0; c < 2; c++) begin
          int l, h;
          l = $urandom_range(0, 1023);
          h = $urandom_range(0, 1023);
          if (l > h && ($urandom_range(0, 3) != 0)) begin int t; t = l; l = h; h = t; end
          wr(p, c, l, h, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0));
        end
      for (int k = 0; k < 30; k++) begin
        int a, b, pp, dd;
        pp = $urandom_range(0, 7);
        dd = $urandom_range(0, 2) - 1;
        if ($urandom_range(0, 1) == 0) begin
          a = $urandom_range(0, 1023); b = $urandom_range(0, 1023);
        end else begin
          a = int'(($urandom_range(0, 1) != 0) ? m_lo[0][pp] : m_hi[0][pp]) + dd;
          b = int'(($urandom_range(0, 1) != 0) ? m_lo[1][pp] : m_hi[1][pp]) + dd;
          if (a < 0) a = 0; if (a > 1023) a = 1023;
          if (b < 0) b = 0; if (b > 1023) b = 1023;
        end
        evaluate(a, b, "R3 R4 R5 random");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule